// File: doc/BRIEF.md
# Multiplexed-Bus SRAM Interface Glue

This block sits between a processor bus whose low address byte and data byte share one set of eight lines and an 8 KB asynchronous static RAM. During the first half of each bus cycle the shared lines carry the low address byte. A transparent latch, opened by the address strobe, captures that byte so the SRAM sees a complete 13-bit address for the whole cycle. The upper address lines arrive on their own pins and are passed straight to the SRAM.

The top three address bits select one of eight 8 KB blocks of the 64 KB space. Only the block chosen by the parameter `WIN_IDX` (by default block 2, i.e. addresses 0x4000 to 0x5FFF) reaches the SRAM. The decode, the write strobe and the read strobe are all qualified by the E clock, so the SRAM is only active in the second, data-carrying half of the cycle. In that half the glue returns read data onto the shared lines, or presents write data from the shared lines to the SRAM data pins. At every other time both of its bus drivers are released.

Top module: `muxbus_sram_glue`

## Requirements
- R1: While `as_i` is 1 the low byte `sram_addr_o[7:0]` follows `ad_io`. After `as_i` falls it holds the value seen at the falling edge, whatever `ad_io` does next.
- R2: `sram_addr_o[12:8]` always equals `addr_hi_i[4:0]`.
- R3: `sram_ce_n_o` is 0 only when `e_i` is 1 and `addr_hi_i[7:5]` equals 3'b010 (addresses 0x4000 to 0x5FFF). Otherwise it is 1, and this includes every access outside that window.
- R4: `sram_we_n_o` is 0 only when `e_i` is 1, `rw_i` is 0 (write) and the address is in the window. Otherwise it is 1.
- R5: `sram_oe_n_o` is 0 only when `e_i` is 1, `rw_i` is 1 (read) and the address is in the window. Otherwise it is 1.
- R6: `sram_ce_o`, the active-high chip enable, is always 1.
- R7: The glue drives `ad_io` with the SRAM data only during an in-window read with `e_i` high. At all other times it leaves `ad_io` undriven, so a value driven by the bus master appears unchanged.
- R8: During an in-window write with `e_i` high, the value on `ad_io` appears on `sram_dq_io`.
- R9: While `rst_ni` is 0, the latched low byte reads 0 and all three active-low strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| e_i | input | 1 | E clock; high marks the data half of a cycle |
| as_i | input | 1 | Address strobe; high opens the low-byte latch |
| rw_i | input | 1 | Cycle direction, 1 read, 0 write |
| addr_hi_i | input | 8 | Upper address byte A15..A8 |
| ad_io | inout | 8 | Shared low-address / data lines |
| sram_addr_o | output | 13 | SRAM address |
| sram_ce_n_o | output | 1 | SRAM chip enable, active low |
| sram_ce_o | output | 1 | SRAM chip enable, active high |
| sram_we_n_o | output | 1 | SRAM write enable, active low |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |
| sram_dq_io | inout | 8 | SRAM data pins |

## Verification
On every E edge the assertions check four things. All strobes are idle while E is low. A write strobe always comes with chip select and a write cycle. A read strobe always comes with chip select and a read cycle. An out-of-window address never produces any strobe. Other behaviour can only be shown by the bench's scenarios. These are the latch holding the low byte after the strobe falls while the lines switch to data, the return of SRAM data onto the shared lines, the passing of write data to the SRAM, the absence of contention during the address phase and out-of-window reads, the edges of the window, and the reset state.

// File: rtl/glue_pkg.sv
package glue_pkg;
  typedef enum logic {
    BUS_WR = 1'b0,
    BUS_RD = 1'b1
  } bus_dir_e;
endpackage

// File: rtl/glue_addr_latch.sv
module glue_addr_latch #(
  parameter int W = 8
) (
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // transparent while le_i high, holds from its falling edge
  always_latch begin
    if (!rst_ni)   q_o = '0;
    else if (le_i) q_o = d_i;
  end
endmodule

// File: rtl/glue_win_decode.sv
module glue_win_decode #(
  parameter int BLK_W   = 3,
  parameter int WIN_IDX = 2
) (
  input  logic             en_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             hit_o
);
  localparam logic [BLK_W-1:0] WIN = BLK_W'(WIN_IDX);

  assign hit_o = en_i && (blk_i == WIN);
endmodule

// File: rtl/glue_strobes.sv
module glue_strobes
  import glue_pkg::*;
(
  input  logic rst_ni,
  input  logic e_i,
  input  logic hit_i,
  input  logic rw_i,
  output logic ce_n_o,
  output logic we_n_o,
  output logic oe_n_o,
  output logic rd_drv_o,
  output logic wr_drv_o
);
  bus_dir_e dir;
  logic     act;

  assign dir      = bus_dir_e'(rw_i);
  assign act      = rst_ni && e_i && hit_i;
  assign ce_n_o   = !act;
  assign we_n_o   = !(act && dir == BUS_WR);
  assign oe_n_o   = !(act && dir == BUS_RD);
  assign rd_drv_o = act && dir == BUS_RD;
  assign wr_drv_o = act && dir == BUS_WR;
endmodule

// File: rtl/glue_data_route.sv
module glue_data_route #(
  parameter int W = 8
) (
  input  logic         rd_en_i,
  input  logic         wr_en_i,
  inout  wire  [W-1:0] bus_io,
  inout  wire  [W-1:0] mem_io
);
  assign bus_io = rd_en_i ? mem_io : {W{1'bz}};
  assign mem_io = wr_en_i ? bus_io : {W{1'bz}};
endmodule

// File: rtl/muxbus_sram_glue.sv
module muxbus_sram_glue #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int MEM_AW  = 13,
  parameter int WIN_IDX = 2
) (
  input  logic                         rst_ni,
  input  logic                         e_i,
  input  logic                         as_i,
  input  logic                         rw_i,
  input  logic [ADDR_W-DATA_W-1:0]     addr_hi_i,
  inout  wire  [DATA_W-1:0]            ad_io,
  output logic [MEM_AW-1:0]            sram_addr_o,
  output logic                         sram_ce_n_o,
  output logic                         sram_ce_o,
  output logic                         sram_we_n_o,
  output logic                         sram_oe_n_o,
  inout  wire  [DATA_W-1:0]            sram_dq_io
);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int BLK_W = ADDR_W - MEM_AW;
  localparam int PASS  = MEM_AW - DATA_W;

  logic [DATA_W-1:0] lo_q;
  logic              hit;
  logic              rd_drv;
  logic              wr_drv;

  glue_addr_latch #(.W(DATA_W)) u_lo_latch (
    .rst_ni (rst_ni),
    .le_i   (as_i),
    .d_i    (ad_io),
    .q_o    (lo_q)
  );

  glue_win_decode #(.BLK_W(BLK_W), .WIN_IDX(WIN_IDX)) u_dec (
    .en_i  (e_i),
    .blk_i (addr_hi_i[HI_W-1 -: BLK_W]),
    .hit_o (hit)
  );

  glue_strobes u_stb (
    .rst_ni   (rst_ni),
    .e_i      (e_i),
    .hit_i    (hit),
    .rw_i     (rw_i),
    .ce_n_o   (sram_ce_n_o),
    .we_n_o   (sram_we_n_o),
    .oe_n_o   (sram_oe_n_o),
    .rd_drv_o (rd_drv),
    .wr_drv_o (wr_drv)
  );

  glue_data_route #(.W(DATA_W)) u_route (
    .rd_en_i (rd_drv),
    .wr_en_i (wr_drv),
    .bus_io  (ad_io),
    .mem_io  (sram_dq_io)
  );

  assign sram_addr_o = {addr_hi_i[PASS-1:0], lo_q};
  assign sram_ce_o   = 1'b1;
endmodule

// File: rtl/glue_sva.sv
module glue_sva #(
  parameter int HI_W    = 8,
  parameter int BLK_W   = 3,
  parameter int WIN_IDX = 2
) (
  input logic            rst_ni,
  input logic            e_i,
  input logic            rw_i,
  input logic [HI_W-1:0] addr_hi_i,
  input logic            sram_ce_n_o,
  input logic            sram_we_n_o,
  input logic            sram_oe_n_o
);
  localparam logic [BLK_W-1:0] WIN = BLK_W'(WIN_IDX);

  // sampled just before E rises, i.e. with E low
  p_idle_e_low_r3: assert property (@(posedge e_i) disable iff (!rst_ni)
    sram_ce_n_o && sram_we_n_o && sram_oe_n_o);

  p_we_sel_wr_r4: assert property (@(negedge e_i) disable iff (!rst_ni)
    !sram_we_n_o |-> (!sram_ce_n_o && !rw_i));

  p_oe_sel_rd_r5: assert property (@(negedge e_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> (!sram_ce_n_o && rw_i));

  p_outside_quiet_r3: assert property (@(negedge e_i) disable iff (!rst_ni)
    (addr_hi_i[HI_W-1 -: BLK_W] != WIN) |->
      (sram_ce_n_o && sram_we_n_o && sram_oe_n_o));
endmodule

bind muxbus_sram_glue glue_sva #(
  .HI_W    (ADDR_W - DATA_W),
  .BLK_W   (ADDR_W - MEM_AW),
  .WIN_IDX (WIN_IDX)
) u_sva (
  .rst_ni      (rst_ni),
  .e_i         (e_i),
  .rw_i        (rw_i),
  .addr_hi_i   (addr_hi_i),
  .sram_ce_n_o (sram_ce_n_o),
  .sram_we_n_o (sram_we_n_o),
  .sram_oe_n_o (sram_oe_n_o)
);

// File: tb/muxbus_sram_glue_bench.sv
`timescale 1ns/1ps
module muxbus_sram_glue_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        e = 1'b0;
  logic        as_s = 1'b0;
  logic        rw = 1'b1;
  logic [7:0]  hi = 8'h00;
  logic [7:0]  ad_drv = 8'h00;
  logic        ad_en = 1'b0;
  wire  [7:0]  ad_io;
  wire  [7:0]  sram_dq_io;
  logic [12:0] sram_addr;
  logic        ce_n, ce, we_n, oe_n;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mdl(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], a[12:10]};
  endfunction

  assign ad_io      = ad_en ? ad_drv : 8'hzz;
  assign sram_dq_io = (!oe_n && !ce_n && ce) ? mdl(sram_addr) : 8'hzz;

  muxbus_sram_glue u_muxbus_sram_glue (
    .rst_ni      (rst_ni),
    .e_i         (e),
    .as_i        (as_s),
    .rw_i        (rw),
    .addr_hi_i   (hi),
    .ad_io       (ad_io),
    .sram_addr_o (sram_addr),
    .sram_ce_n_o (ce_n),
    .sram_ce_o   (ce),
    .sram_we_n_o (we_n),
    .sram_oe_n_o (oe_n),
    .sram_dq_io  (sram_dq_io)
  );

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // {hi, lo, rw, data}
  localparam logic [24:0] VEC [8] = '{
    {8'h40, 8'h12, 1'b1, 8'h00},
    {8'h5F, 8'hFE, 1'b1, 8'h00},
    {8'h3F, 8'h77, 1'b1, 8'h00},
    {8'h60, 8'h01, 1'b1, 8'h00},
    {8'h4A, 8'h5C, 1'b0, 8'hC3},
    {8'h5F, 8'hFF, 1'b0, 8'h81},
    {8'h20, 8'h10, 1'b0, 8'h99},
    {8'hE0, 8'hAA, 1'b1, 8'h00}
  };

  task automatic bus_cycle(input logic [7:0] h, input logic [7:0] lo,
                           input logic r, input logic [7:0] d);
    logic        inw;
    logic [12:0] a;
    inw = (h[7:5] == 3'b010);
    a   = {h[4:0], lo};
    @(posedge clk);
    e = 1'b0; as_s = 1'b1; hi = h; rw = r; ad_drv = lo; ad_en = 1'b1;
    @(negedge clk);
    chk(ce_n && we_n && oe_n, "R3 idle in address phase", {13'd0, ce_n, we_n, oe_n}, 16'h7);
    chk(ad_io == lo, "R7 no drive in address phase", ad_io, lo);
    chk(sram_addr == a, "R1 transparent", sram_addr, a);
    @(posedge clk);
    as_s = 1'b0;
    @(posedge clk);
    if (!r) ad_drv = d;
    else if (!inw) ad_drv = 8'h3C;
    else ad_en = 1'b0;
    e = 1'b1;
    @(negedge clk);
    chk(sram_addr == a, "R1 R2 address held in data phase", sram_addr, a);
    chk(ce_n == !inw, "R3 chip select", ce_n, !inw);
    chk(we_n == !(inw && !r), "R4 write strobe", we_n, !(inw && !r));
    chk(oe_n == !(inw && r), "R5 read strobe", oe_n, !(inw && r));
    chk(ce == 1'b1, "R6 high enable", ce, 1);
    if (r && inw)  chk(ad_io == mdl(a), "R7 read data returned", ad_io, mdl(a));
    if (r && !inw) chk(ad_io == 8'h3C, "R7 no drive out of window", ad_io, 8'h3C);
    if (!r && inw) chk(sram_dq_io == d, "R8 write data passed", sram_dq_io, d);
    @(posedge clk);
    e = 1'b0; ad_en = 1'b0;
  endtask

  initial begin
    #100000;
    n_fail++; n_chk++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // reset: latch cleared, strobes idle even with E high in window
    as_s = 1'b1; ad_en = 1'b1; ad_drv = 8'h9D; hi = 8'h41; e = 1'b1; rw = 1'b1;
    @(negedge clk);
    chk(sram_addr[7:0] == 8'h00, "R9 latch cleared", sram_addr[7:0], 0);
    chk(ce_n && we_n && oe_n, "R9 strobes idle", {13'd0, ce_n, we_n, oe_n}, 16'h7);
    chk(ce == 1'b1, "R6 high enable in reset", ce, 1);
    @(posedge clk);
    e = 1'b0; as_s = 1'b0; ad_en = 1'b0; rst_ni = 1'b1;
    repeat (2) @(posedge clk);

    foreach (VEC[i]) bus_cycle(VEC[i][24:17], VEC[i][16:9], VEC[i][8], VEC[i][7:0]);

    // latch follows then holds
    @(posedge clk); as_s = 1'b1; ad_en = 1'b1; ad_drv = 8'h11; hi = 8'h40;
    @(negedge clk);
    chk(sram_addr[7:0] == 8'h11, "R1 follows first", sram_addr[7:0], 8'h11);
    @(posedge clk); ad_drv = 8'h22;
    @(negedge clk);
    chk(sram_addr[7:0] == 8'h22, "R1 follows change", sram_addr[7:0], 8'h22);
    @(posedge clk); as_s = 1'b0;
    @(posedge clk); ad_drv = 8'hE7;
    @(negedge clk);
    chk(sram_addr[7:0] == 8'h22, "R1 holds after fall", sram_addr[7:0], 8'h22);
    @(posedge clk); hi = 8'h5B;
    @(negedge clk);
    chk(sram_addr[12:8] == 5'h1B, "R2 upper bits pass", sram_addr[12:8], 5'h1B);
    ad_en = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule